// File: doc/BRIEF.md
# String Load Sequencer

This block carries out a string-load operation for a small processor datapath. When it is started, it captures a source index, a count and an accumulator value. It then reads one element from memory at the address held in the source index. The element is a byte, a 16-bit word, a 32-bit doubleword or a 64-bit quadword. The element is merged into the low end of the accumulator, and any accumulator bits above the element are kept.

After each element is accepted, the index moves by the element size in bytes. A direction input selects whether it counts up or down. The index wraps modulo the address width.

In repeat mode, the single transfer runs once per unit of the captured count. The count drops by one after each accepted element, and a count of zero performs no read at all. Memory is reached through a request/valid handshake. A one-cycle done pulse marks the end of a single load or of a whole repeat sequence, and a start request is ignored while the block is busy.

Top module: `strload_seq`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done` and `rd_req` are 0.
- R2: Each read presents `rd_addr` equal to the current index and `rd_size` equal to the size code. It holds `rd_req`, `rd_addr` and `rd_size` stable until `rd_valid` is seen. The reads of one operation occur in index-stepping order.
- R3: Size code 0 (byte) replaces accumulator bits [7:0] with read data bits [7:0] and leaves all higher accumulator bits unchanged. The index steps by 1.
- R4: Size code 1 (word) replaces accumulator bits [15:0] and keeps the higher bits. The index steps by 2.
- R5: Size code 2 (doubleword) replaces accumulator bits [31:0] and keeps the higher bits. The index steps by 4.
- R6: Size code 3 (quadword, available when `QUAD_EN` is 1) replaces all 64 accumulator bits. The index steps by 8.
- R7: With `op_dir` = 0 the index increases by the step after each accepted element. With `op_dir` = 1 it decreases by the step. The index changes only in a cycle where `rd_req` and `rd_valid` are both high.
- R8: The index wraps modulo 2^ADDR_W in both directions.
- R9: With `op_rep` = 1 and a nonzero count N, exactly N reads are made. The count drops by one per accepted element, and the operation ends with the count at 0.
- R10: With `op_rep` = 1 and a count of 0, no read is issued. The index and accumulator keep their start values, and `done` pulses in the cycle after the start.
- R11: `done` is high for exactly one cycle per operation. A `start` while `busy` is high has no effect on the operation in progress.
- R12: With `op_rep` = 0, exactly one read is made whatever the count, and the count register keeps its start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op_size | input | 2 | Element size: 0 byte, 1 word, 2 doubleword, 3 quadword |
| op_dir | input | 1 | 0 step index up, 1 step index down |
| op_rep | input | 1 | 1 repeat by count, 0 single load |
| idx_init | input | ADDR_W | Starting source index |
| cnt_init | input | CNT_W | Starting repeat count |
| acc_init | input | DATA_W | Starting accumulator value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| idx_q | output | ADDR_W | Current source index |
| cnt_q | output | CNT_W | Current repeat count |
| acc_q | output | DATA_W | Current accumulator |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_size | output | 2 | Read size code |
| rd_valid | input | 1 | Read data returned this cycle |
| rd_data | input | DATA_W | Read data, element in low bits |

## Verification
The bench builds the block with its default parameters: a 16-bit index, an 8-bit count, a 64-bit accumulator and the quadword variant enabled. With the 16-bit index, both wrap directions can be reached by starting at 0x0000 or near 0xFFFF. With the quadword variant enabled, all four size codes and their steps of 1, 2, 4 and 8 are exercised. The memory responder varies its latency so that the hold-until-valid rule of the handshake is stressed across several wait cycles.

// File: rtl/strload_pkg.sv
package strload_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_QWORD = 2'd3
   } elem_sz_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_FIN  = 2'd2
   } seq_st_t;
endpackage

// File: rtl/strload_size_dec.sv
module strload_size_dec
   import strload_pkg::*;
#(
   parameter int LANES = 8
) (
   input  elem_sz_t           sz,
   output logic [LANES-1:0]   lane_mask,
   output logic [3:0]         step
);
   always_comb begin
      unique case (sz)
         SZ_BYTE:  step = 4'd1;
         SZ_WORD:  step = 4'd2;
         SZ_DWORD: step = 4'd4;
         default:  step = 4'd8;
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_mask[i] = (i < int'(step));
   end
endmodule

// File: rtl/strload_ptr_step.sv
module strload_ptr_step #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] cur,
   input  logic [3:0]        step,
   input  logic              down,
   output logic [ADDR_W-1:0] nxt
);
   localparam int PAD = ADDR_W - 4;
   logic [ADDR_W-1:0] delta;

   assign delta = {{PAD{1'b0}}, step};
   assign nxt   = down ? (cur - delta) : (cur + delta);
endmodule

// File: rtl/strload_acc_merge.sv
module strload_acc_merge #(
   parameter int LANES = 8
) (
   input  logic [LANES*8-1:0] acc,
   input  logic [LANES*8-1:0] data,
   input  logic [LANES-1:0]   mask,
   output logic [LANES*8-1:0] merged
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[i*8 +: 8] = mask[i] ? data[i*8 +: 8] : acc[i*8 +: 8];
   end
endmodule

// File: rtl/strload_seq.sv
module strload_seq
   import strload_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 64,
   parameter bit QUAD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_size,
   input  logic              op_dir,
   input  logic              op_rep,
   input  logic [ADDR_W-1:0] idx_init,
   input  logic [CNT_W-1:0]  cnt_init,
   input  logic [DATA_W-1:0] acc_init,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] idx_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [DATA_W-1:0] acc_q,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [1:0]        rd_size,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data
);
   localparam int LANES = DATA_W / 8;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (ADDR_W < 4) begin : g_chk_addr
      $error("strload_seq: ADDR_W must be at least 4");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("strload_seq: CNT_W must be at least 1");
   end
   if (DATA_W != (QUAD_EN ? 64 : 32)) begin : g_chk_data
      $error("strload_seq: DATA_W must be 64 with quadwords, else 32");
   end

   seq_st_t           st_q;
   elem_sz_t          sz_q;
   elem_sz_t          sz_norm;
   logic              dir_q;
   logic              rep_q;
   logic              accept;
   logic              launch;
   logic [LANES-1:0]  mask;
   logic [3:0]        step;
   logic [ADDR_W-1:0] idx_nxt;
   logic [DATA_W-1:0] acc_nxt;

   if (QUAD_EN) begin : g_quad
      assign sz_norm = elem_sz_t'(op_size);
   end else begin : g_noquad
      assign sz_norm = (elem_sz_t'(op_size) == SZ_QWORD) ? SZ_DWORD : elem_sz_t'(op_size);
   end

   strload_size_dec #(.LANES(LANES)) u_dec (
      .sz        (sz_q),
      .lane_mask (mask),
      .step      (step)
   );

   strload_ptr_step #(.ADDR_W(ADDR_W)) u_ptr (
      .cur  (idx_q),
      .step (step),
      .down (dir_q),
      .nxt  (idx_nxt)
   );

   strload_acc_merge #(.LANES(LANES)) u_merge (
      .acc    (acc_q),
      .data   (rd_data),
      .mask   (mask),
      .merged (acc_nxt)
   );

   assign busy    = (st_q != ST_IDLE);
   assign done    = (st_q == ST_FIN);
   assign rd_req  = (st_q == ST_READ);
   assign rd_addr = idx_q;
   assign rd_size = sz_q;
   assign launch  = start && (st_q == ST_IDLE);
   assign accept  = rd_req && rd_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         sz_q  <= SZ_BYTE;
         dir_q <= 1'b0;
         rep_q <= 1'b0;
         idx_q <= '0;
         cnt_q <= '0;
         acc_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (launch) begin
                  sz_q  <= sz_norm;
                  dir_q <= op_dir;
                  rep_q <= op_rep;
                  idx_q <= idx_init;
                  cnt_q <= cnt_init;
                  acc_q <= acc_init;
                  st_q  <= (op_rep && (cnt_init == '0)) ? ST_FIN : ST_READ;
               end
            end
            ST_READ: begin
               if (accept) begin
                  idx_q <= idx_nxt;
                  acc_q <= acc_nxt;
                  if (rep_q) begin
                     cnt_q <= cnt_q - CNT_ONE;
                     if (cnt_q == CNT_ONE) st_q <= ST_FIN;
                  end else begin
                     st_q <= ST_FIN;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr) && $stable(rd_size))); // R2
   AST_IDX_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !accept) |=> $stable(idx_q)); // R7
   AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rep_q) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R9
   AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && op_rep && (cnt_init == '0)) |=> (done && !rd_req)); // R10
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_SINGLE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !rep_q) |=> (done && $stable(cnt_q))); // R12
endmodule

// File: tb/strload_seq_test.sv
module strload_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_size = '0;
   logic        op_dir = 1'b0;
   logic        op_rep = 1'b0;
   logic [15:0] idx_init = '0;
   logic [7:0]  cnt_init = '0;
   logic [63:0] acc_init = '0;
   logic        busy, done, rd_req;
   logic [15:0] idx_q, rd_addr;
   logic [7:0]  cnt_q;
   logic [63:0] acc_q;
   logic [1:0]  rd_size;
   logic        rd_valid = 1'b0;
   logic [63:0] rd_data = '0;

   int total = 0;
   int bad = 0;
   int reads = 0;
   int lat = 0;
   int wcnt = 0;
   logic [17:0] expq[$];

   always #5 clk = ~clk;

   strload_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_size(op_size),
      .op_dir(op_dir), .op_rep(op_rep), .idx_init(idx_init),
      .cnt_init(cnt_init), .acc_init(acc_init), .busy(busy), .done(done),
      .idx_q(idx_q), .cnt_q(cnt_q), .acc_q(acc_q), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_size(rd_size), .rd_valid(rd_valid),
      .rd_data(rd_data)
   );

   function automatic logic [63:0] mem_at(input logic [15:0] a);
      return {a, a ^ 16'hA5C3, ~a, a + 16'h0101};
   endfunction

   function automatic logic [63:0] merge(input logic [63:0] acc,
                                         input logic [63:0] d,
                                         input logic [1:0] sz);
      case (sz)
         2'd0: return {acc[63:8], d[7:0]};
         2'd1: return {acc[63:16], d[15:0]};
         2'd2: return {acc[63:32], d[31:0]};
         default: return d;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Monitor / memory responder: pops the expected request and compares it.
   always @(negedge clk) begin
      if (rd_valid) begin
         rd_valid = 1'b0;
         wcnt = 0;
      end else if (rd_req) begin
         if (wcnt >= lat) begin
            if (expq.size() == 0) begin
               check(1'b0, "R2", "unexpected read", {46'd0, rd_size, rd_addr}, 64'd0);
            end else begin
               logic [17:0] e;
               e = expq.pop_front();
               check({rd_size, rd_addr} == e, "R2", "read addr/size",
                     {46'd0, rd_size, rd_addr}, {46'd0, e});
            end
            reads++;
            rd_data = mem_at(rd_addr);
            rd_valid = 1'b1;
         end else begin
            wcnt++;
         end
      end
   end

   // Driver: pushes expected reads, runs the operation, checks the end state.
   task automatic run_op(input string req, input logic [1:0] sz, input logic dir,
                         input logic rep, input logic [15:0] idx,
                         input logic [7:0] cnt, input logic [63:0] acc,
                         input int latency, input bit poke);
      int n;
      int guard;
      logic [15:0] a;
      logic [63:0] e_acc;
      logic [3:0] st;
      st = (sz == 2'd0) ? 4'd1 : (sz == 2'd1) ? 4'd2 : (sz == 2'd2) ? 4'd4 : 4'd8;
      n = rep ? int'(cnt) : 1;
      a = idx;
      e_acc = acc;
      for (int k = 0; k < n; k++) begin
         expq.push_back({sz, a});
         e_acc = merge(e_acc, mem_at(a), sz);
         a = dir ? a - 16'(st) : a + 16'(st);
      end
      reads = 0;
      lat = latency;
      @(negedge clk);
      op_size = sz; op_dir = dir; op_rep = rep;
      idx_init = idx; cnt_init = cnt; acc_init = acc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R11: a start while busy must not disturb the operation
         op_size = 2'd3; op_dir = ~dir; op_rep = 1'b0;
         idx_init = 16'h7777; cnt_init = 8'd1; acc_init = '0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      check(done, req, "done not seen (watchdog)", {63'd0, done}, 64'd1);
      check(idx_q == a, req, "final index", {48'd0, idx_q}, {48'd0, a});
      check(acc_q == e_acc, req, "final accumulator", acc_q, e_acc);
      check(cnt_q == (rep ? 8'd0 : cnt), req, "final count", {56'd0, cnt_q},
            {56'd0, (rep ? 8'd0 : cnt)});
      check(reads == n && expq.size() == 0, req, "read count",
            64'(reads), 64'(n));
      @(negedge clk);
      check(!done, "R11", "done longer than one cycle", {63'd0, done}, 64'd0);
      expq.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !rd_req, "R1", "reset outputs",
            {61'd0, busy, done, rd_req}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !rd_req, "R1", "after reset",
            {61'd0, busy, done, rd_req}, 64'd0);

      run_op("R3", 2'd0, 1'b0, 1'b0, 16'h1000, 8'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0);
      run_op("R4", 2'd1, 1'b1, 1'b0, 16'h2002, 8'd0, 64'h1122_3344_5566_7788, 2, 1'b0);
      run_op("R5", 2'd2, 1'b0, 1'b0, 16'h3004, 8'd0, 64'hDEAD_BEEF_CAFE_F00D, 1, 1'b0);
      run_op("R6", 2'd3, 1'b0, 1'b0, 16'hFFFC, 8'd0, 64'h0, 3, 1'b0);
      run_op("R8", 2'd0, 1'b1, 1'b0, 16'h0000, 8'd0, 64'hAAAA_AAAA_AAAA_AAAA, 0, 1'b0);
      run_op("R7", 2'd2, 1'b1, 1'b1, 16'h0008, 8'd4, 64'h5555_0000_5555_0000, 1, 1'b0);
      run_op("R9", 2'd1, 1'b0, 1'b1, 16'hFFFC, 8'd3, 64'h0123_4567_89AB_CDEF, 2, 1'b0);
      run_op("R10", 2'd2, 1'b0, 1'b1, 16'h4444, 8'd0, 64'h0F0F_0F0F_0F0F_0F0F, 0, 1'b0);
      run_op("R12", 2'd1, 1'b0, 1'b0, 16'h5000, 8'd5, 64'h0, 1, 1'b0);
      run_op("R11", 2'd0, 1'b0, 1'b1, 16'h6000, 8'd4, 64'h1, 3, 1'b1);
      run_op("R9", 2'd3, 1'b1, 1'b1, 16'h0010, 8'd6, 64'h0, 0, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule